// File: doc/BRIEF.md
# Clamped Shift Unit

This block shifts a data word A by an amount B, to the left or to the right, in a single registered stage. Control inputs travel with each beat. They choose the direction, arithmetic (sign-filling) or logical right shift, and how an amount wider than the word is handled. In wrap mode only the low five bits of the amount are used. In saturate mode the full 32-bit amount is compared without sign, and any amount of 32 or more gives either all zeros or a word filled with the sign bit. A right shift can first mirror A end to end.

B is a full-width value that has already been formed upstream. An immediate amount arrives sign-extended from 20 bits, so a negative immediate becomes a very large unsigned amount and falls under the saturate rule. Beats enter and leave through valid/ready handshakes:
- An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new beat is taken.

Top module: `clamp_shift_unit`

## Requirements
- R1: While synchronous active-high `rst` is sampled high, `out_valid` and `out_data` are zero on the following cycle. After reset, `in_ready` is high.
- R2: With `in_wrap` = 1, only amount bits [4:0] are used: the amount is ANDed with 31 before the shift, in every direction.
- R3: With `in_wrap` = 0, a left shift by an unsigned amount of 32 or more returns zero. This includes sign-extended negative immediates such as 0xFFFFFFFF.
- R4: With `in_wrap` = 0, a logical right shift (`in_arith` = 0) by 32 or more returns zero.
- R5: With `in_wrap` = 0, an arithmetic right shift by 32 or more returns 32 copies of bit 31 of the (possibly mirrored) source.
- R6: For amounts below 32, `in_right` = 0 gives A<<B. `in_right` = 1 gives A>>B, filled with zeros when `in_arith` = 0 and with bit 31 when `in_arith` = 1.
- R7: With `in_mirror` = 1 on a right shift, A is bit-reversed (bit i moves to bit 31-i) before shifting. An arithmetic shift takes its sign from the reversed word.
- R8: On a left shift, `in_mirror` and `in_arith` have no effect on the result.
- R9: The result of a beat accepted on edge n appears on `out_data` with `out_valid` high after edge n.
- R10: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is low and `out_data` and `out_valid` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_a | input | 32 | Word to shift |
| in_amt | input | 32 | Shift amount, full width, unsigned |
| in_right | input | 1 | 1 = right shift, 0 = left shift |
| in_arith | input | 1 | Right shift fills with the sign bit |
| in_wrap | input | 1 | 1 = use amount bits [4:0]; 0 = saturate at 32 or more |
| in_mirror | input | 1 | Bit-reverse A before a right shift |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Shifted result |

## Verification
The bench builds the unit with its default word width of 32, which gives a five-bit amount field. At this width the edge between 31 and 32 can be reached, along with amounts such as 33 and 0x25 whose low bits differ from their full value. It also reaches 0xFFFFFFFF, the value a sign-extended negative 20-bit immediate produces. The bench compares each result with a separate behavioural model built on the language's shift operators. It also holds the consumer stalled to check that the output register stays put.

// File: rtl/clamp_shift_pkg.sv
package clamp_shift_pkg;

  typedef struct packed {
    logic right;
    logic arith;
    logic wrap;
    logic mirror;
  } shift_ctl_t;

endpackage

// File: rtl/shift_amount_ctl.sv
module shift_amount_ctl #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         amt,
  input  logic                      wrap,
  output logic [$clog2(DATA_W)-1:0] eff_amt,
  output logic                      saturate
);
  localparam int AMT_W = $clog2(DATA_W);

  // Wrap mode keeps only the low bits; saturate mode flags any upper bit.
  assign eff_amt  = amt[AMT_W-1:0];
  assign saturate = !wrap && (amt[DATA_W-1:AMT_W] != '0);
endmodule

// File: rtl/shift_core.sv
module shift_core
  import clamp_shift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         a,
  input  logic [$clog2(DATA_W)-1:0] amt,
  input  logic                      saturate,
  input  shift_ctl_t                ctl,
  output logic [DATA_W-1:0]         result
);
  localparam int AMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] a_rev;
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] stage [0:AMT_W];
  logic [DATA_W-1:0] shifted;
  logic              fill;

  genvar i;
  generate
    for (i = 0; i < DATA_W; i++) begin : g_rev_in
      assign a_rev[i] = a[DATA_W-1-i];
    end
  endgenerate

  // A left shift is a right shift of the mirrored word, mirrored back.
  always_comb begin
    if (!ctl.right)     src = a_rev;
    else if (ctl.mirror) src = a_rev;
    else                src = a;
  end

  assign fill     = ctl.right && ctl.arith && src[DATA_W-1];
  assign stage[0] = src;

  genvar s;
  generate
    for (s = 0; s < AMT_W; s++) begin : g_stage
      localparam int STEP = 1 << s;
      assign stage[s+1] = amt[s] ? {{STEP{fill}}, stage[s][DATA_W-1:STEP]} : stage[s];
    end
  endgenerate

  assign shifted = saturate ? {DATA_W{fill}} : stage[AMT_W];

  generate
    for (i = 0; i < DATA_W; i++) begin : g_rev_out
      assign result[i] = ctl.right ? shifted[i] : shifted[DATA_W-1-i];
    end
  endgenerate
endmodule

// File: rtl/clamp_shift_unit.sv
module clamp_shift_unit
  import clamp_shift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_amt,
  input  logic              in_right,
  input  logic              in_arith,
  input  logic              in_wrap,
  input  logic              in_mirror,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int AMT_W = $clog2(DATA_W);

  shift_ctl_t        ctl;
  logic [AMT_W-1:0]  eff_amt;
  logic              saturate;
  logic [DATA_W-1:0] result;
  logic              accept;

  assign ctl = '{right: in_right, arith: in_arith, wrap: in_wrap, mirror: in_mirror};

  shift_amount_ctl #(.DATA_W(DATA_W)) u_amt (
    .amt(in_amt), .wrap(in_wrap), .eff_amt(eff_amt), .saturate(saturate)
  );

  shift_core #(.DATA_W(DATA_W)) u_core (
    .a(in_a), .amt(eff_amt), .saturate(saturate), .ctl(ctl), .result(result)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= result;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_left_clamp_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_wrap && !in_right && in_amt >= DATA_W) |=> (out_data == '0));

  assert_lsr_clamp_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_wrap && in_right && !in_arith && in_amt >= DATA_W) |=> (out_data == '0));

  assert_asr_clamp_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_wrap && in_right && in_arith && !in_mirror && in_amt >= DATA_W)
      |=> (out_data == {DATA_W{$past(in_a[DATA_W-1])}}));
endmodule

// File: tb/tb_clamp_shift_unit.sv
module tb_clamp_shift_unit;
  logic        clk = 0;
  logic        rst;
  logic        in_valid, in_ready;
  logic [31:0] in_a, in_amt;
  logic        in_right, in_arith, in_wrap, in_mirror;
  logic        out_valid, out_ready;
  logic [31:0] out_data;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  clamp_shift_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_amt(in_amt), .in_right(in_right), .in_arith(in_arith),
    .in_wrap(in_wrap), .in_mirror(in_mirror), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] amt,
                                        input logic right, input logic arith,
                                        input logic wrap, input logic mirror);
    logic [31:0] src;
    logic [31:0] sh;
    src = a;
    if (right && mirror)
      for (int k = 0; k < 32; k++) src[k] = a[31-k];
    sh = wrap ? (amt & 32'd31) : amt;
    if (sh >= 32) begin
      if (right && arith) return {32{src[31]}};
      return 32'd0;
    end
    if (!right) return a << sh;
    if (arith)  return $unsigned($signed(src) >>> sh);
    return src >> sh;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input string req, input logic [31:0] a, input logic [31:0] amt,
                      input logic right, input logic arith, input logic wrap, input logic mirror);
    @(negedge clk);
    in_a = a; in_amt = amt; in_right = right; in_arith = arith;
    in_wrap = wrap; in_mirror = mirror; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, out_data, model(a, amt, right, arith, wrap, mirror));
  endtask

  task automatic t_reset;
    rst = 1; in_valid = 0; out_ready = 1;
    in_a = 0; in_amt = 0; in_right = 0; in_arith = 0; in_wrap = 0; in_mirror = 0;
    repeat (3) @(negedge clk);
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 out_data", out_data, 32'd0);
    rst = 0;
    @(negedge clk);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_wrap;
    send("R2 left 33", 32'h0000_00F1, 32'd33, 0, 0, 1, 0);
    send("R2 right 0x25", 32'hF000_0000, 32'h25, 1, 0, 1, 0);
    send("R2 asr big", 32'h8000_0000, 32'hFFFF_FFE4, 1, 1, 1, 0);
    send("R2 amount 32 wraps to 0", 32'h1234_5678, 32'd32, 1, 1, 1, 0);
  endtask

  task automatic t_clamp;
    send("R3 left 32", 32'hFFFF_FFFF, 32'd32, 0, 0, 0, 0);
    send("R3 left neg imm", 32'h0000_0001, 32'hFFFF_FFFF, 0, 0, 0, 0);
    send("R4 lsr 40", 32'hFFFF_FFFF, 32'd40, 1, 0, 0, 0);
    send("R5 asr neg", 32'h8000_0001, 32'h0001_0000, 1, 1, 0, 0);
    send("R5 asr pos", 32'h7FFF_FFFF, 32'd32, 1, 1, 0, 0);
  endtask

  task automatic t_range;
    send("R6 left 31", 32'h0000_0003, 32'd31, 0, 0, 0, 0);
    send("R6 lsr 4", 32'h8765_4321, 32'd4, 1, 0, 0, 0);
    send("R6 asr 31", 32'h8000_0000, 32'd31, 1, 1, 0, 0);
    send("R6 asr 0", 32'hC3C3_0000, 32'd0, 1, 1, 0, 0);
  endtask

  task automatic t_mirror;
    send("R7 mirror lsr", 32'h0000_0001, 32'd3, 1, 0, 0, 0);
    send("R7 mirror lsr", 32'h0000_0001, 32'd3, 1, 0, 0, 1);
    send("R7 mirror asr sign", 32'h0000_0001, 32'd4, 1, 1, 0, 1);
    send("R7 mirror asr clamp", 32'h0000_0001, 32'd50, 1, 1, 0, 1);
  endtask

  task automatic t_left_ignore;
    send("R8 left mirror+arith", 32'h8000_00F0, 32'd4, 0, 1, 0, 1);
    send("R8 left mirror clamp", 32'h8000_0001, 32'd64, 0, 1, 0, 1);
  endtask

  task automatic t_stall;
    logic [31:0] first;
    @(negedge clk);
    out_ready = 0;
    in_a = 32'hA5A5_0000; in_amt = 32'd8; in_right = 1; in_arith = 1;
    in_wrap = 0; in_mirror = 0; in_valid = 1;
    first = model(32'hA5A5_0000, 32'd8, 1, 1, 0, 0);
    @(negedge clk);
    check("R9 valid after accept", {31'd0, out_valid}, 32'd1);
    check("R9 data", out_data, first);
    check("R10 in_ready low", {31'd0, in_ready}, 32'd0);
    in_a = 32'h0000_FFFF; in_amt = 32'd1; in_right = 0;
    repeat (2) @(negedge clk);
    check("R10 held data", out_data, first);
    check("R10 held valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R10 next beat after release", out_data, 32'h0001_FFFE);
    @(negedge clk);
    check("R9 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_wrap();
    t_clamp();
    t_range();
    t_mirror();
    t_left_ignore();
    t_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule